// File: doc/BRIEF.md
# PCIe Root-Port Bring-Up Sequencer

This block walks a PCIe root port from cold reset to the point where configuration requests may be issued. A single `go` pulse starts an ordered series of steps. The sequencer first selects root-complex mode, then releases the powerdown control, and then releases the soft reset. It waits a settle time, runs a PHY initialisation handshake and pulses a strobe that tells neighbouring logic to program the address-window and translation registers. Next it drives the fundamental reset pin and enables link training. Once the link reports up and a quiet period has passed, it raises `cfg_ready`.

All delays come from one shared down-counter. The delay lengths are given in microseconds and converted to clock cycles through a clock-frequency parameter. The `HAS_PERST` parameter states whether the port has a fundamental-reset pin. Without the pin, the reset pulse and the quiet period after link-up are both skipped. If the link does not come up within a timeout, the sequencer drops link training and raises `link_err`. It holds that state until the next `go`.

Top module: `rp_bringup_seq`

## Requirements
- R1: After synchronous reset, and until `go` is seen, the outputs hold their idle values: `rc_mode`=0, `pwr_down`=1, `soft_rst`=1, `phy_init_req`=0, `regs_setup`=0, `perst_n`=1, `ltssm_en`=0, `cfg_ready`=0, `link_err`=0. `pwr_down` and `soft_rst` are active high and `perst_n` is active low.
- R2: The clock edge after `go` sets `rc_mode`=1 while both resets are still asserted. One cycle later `pwr_down` falls. One cycle after that `soft_rst` falls.
- R3: After `soft_rst` falls, the outputs stay unchanged for exactly SETTLE cycles, where SETTLE = CLK_MHZ×SETTLE_US. `ltssm_en` stays low during this time.
- R4: `phy_init_req` then rises and stays high until a cycle in which `phy_done`=1. `ltssm_en` is low for the whole of that time.
- R5: On the edge that samples `phy_done`, `phy_init_req` falls and `regs_setup` goes high for exactly one cycle.
- R6: With `HAS_PERST`=1, `perst_n` is 0 for exactly CLK_MHZ×PERST_US cycles after the strobe. `ltssm_en` rises on the same edge that releases `perst_n`.
- R7: With `HAS_PERST`=1, `cfg_ready` rises exactly CLK_MHZ×QUIET_US cycles after the edge that samples `link_up`=1. `ltssm_en` stays high from then on.
- R8: If `link_up` has not been seen after CLK_MHZ×LINK_TMO_US cycles with training enabled, `ltssm_en` falls and `link_err` rises. Both stay that way, whatever `link_up` does, until `go`.
- R9: `go` is ignored while a sequence is in progress. In the ready state or the error state, `go` restarts the sequence from R2, and `pwr_down` and `soft_rst` are asserted again.
- R10: With `HAS_PERST`=0, `perst_n` never goes low. `ltssm_en` rises on the edge after the strobe. `cfg_ready` rises on the edge that samples `link_up`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start or restart request |
| phy_done | input | 1 | PHY initialisation finished |
| link_up | input | 1 | Link reported up by the training logic |
| rc_mode | output | 1 | Device-type select, 1 selects root complex |
| pwr_down | output | 1 | Controller powerdown, active high |
| soft_rst | output | 1 | Controller soft reset, active high |
| phy_init_req | output | 1 | PHY initialisation request, held until done |
| regs_setup | output | 1 | One-cycle strobe to program window and translation registers |
| perst_n | output | 1 | Fundamental reset to the link partner, active low |
| ltssm_en | output | 1 | Link-training enable |
| cfg_ready | output | 1 | Configuration requests may be issued |
| link_err | output | 1 | Link-up timeout occurred |

## Verification
Every output is registered from the next-state value, so a wrong state shows as a wrong pin pattern on the very edge the state is entered. For example, an early `ltssm_en` or a missing strobe is visible within one cycle. A wrong timer load or a wrong expiry test does not change the pattern of any phase. It shows up only as a phase that ends a cycle early or late, so each timed phase is checked at the cycle just before its boundary and at the cycle just after it. A missed timeout check shows as training still enabled one cycle after the limit.

// File: rtl/rp_bringup_pkg.sv
package rp_bringup_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_TYPE,
        ST_PWR,
        ST_SETTLE,
        ST_PHY,
        ST_REGS,
        ST_PERST,
        ST_LINK,
        ST_QUIET,
        ST_READY,
        ST_ERR
    } seq_state_e;

    typedef struct packed {
        logic rc_mode;
        logic pwr_down;
        logic soft_rst;
        logic phy_req;
        logic regs_stb;
        logic perst_n;
        logic ltssm_en;
        logic cfg_ready;
        logic link_err;
    } ctl_t;

    localparam ctl_t CTL_IDLE = '{rc_mode: 1'b0, pwr_down: 1'b1, soft_rst: 1'b1,
                                  phy_req: 1'b0, regs_stb: 1'b0, perst_n: 1'b1,
                                  ltssm_en: 1'b0, cfg_ready: 1'b0, link_err: 1'b0};

    // Converts a delay in microseconds into clock cycles (never below one).
    function automatic int unsigned us_to_cyc(int unsigned mhz, int unsigned us);
        int unsigned n;
        n = mhz * us;
        return (n == 0) ? 1 : n;
    endfunction

    function automatic int unsigned max_of(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Pin pattern for each phase.
    function automatic ctl_t ctl_for(seq_state_e s);
        ctl_t c;
        c = CTL_IDLE;
        if (s != ST_IDLE) c.rc_mode = 1'b1;
        case (s)
            ST_IDLE, ST_TYPE: ;
            ST_PWR: c.pwr_down = 1'b0;
            default: begin
                c.pwr_down = 1'b0;
                c.soft_rst = 1'b0;
            end
        endcase
        case (s)
            ST_PHY:            c.phy_req  = 1'b1;
            ST_REGS:           c.regs_stb = 1'b1;
            ST_PERST:          c.perst_n  = 1'b0;
            ST_LINK, ST_QUIET: c.ltssm_en = 1'b1;
            ST_READY: begin
                c.ltssm_en  = 1'b1;
                c.cfg_ready = 1'b1;
            end
            ST_ERR:            c.link_err = 1'b1;
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/rp_phase_timer.sv
module rp_phase_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    // R3: an idle counter never wraps around from zero.
    a_r3_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/rp_seq_ctrl.sv
module rp_seq_ctrl
    import rp_bringup_pkg::*;
#(
    parameter bit          HAS_PERST  = 1'b1,
    parameter int          TW         = 8,
    parameter int unsigned SETTLE_CYC = 4,
    parameter int unsigned PERST_CYC  = 4,
    parameter int unsigned QUIET_CYC  = 4,
    parameter int unsigned TMO_CYC    = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic          phy_done,
    input  logic          link_up,
    input  logic          tmr_expired,
    output seq_state_e    state_d,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val
);
    seq_state_e state_q;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:   if (go) state_d = ST_TYPE;
            ST_TYPE:   state_d = ST_PWR;
            ST_PWR:    state_d = ST_SETTLE;
            ST_SETTLE: if (tmr_expired) state_d = ST_PHY;
            ST_PHY:    if (phy_done) state_d = ST_REGS;
            ST_REGS:   state_d = HAS_PERST ? ST_PERST : ST_LINK;
            ST_PERST:  if (tmr_expired) state_d = ST_LINK;
            ST_LINK: begin
                if (link_up)          state_d = HAS_PERST ? ST_QUIET : ST_READY;
                else if (tmr_expired) state_d = ST_ERR;
            end
            ST_QUIET:  if (tmr_expired) state_d = ST_READY;
            ST_READY:  if (go) state_d = ST_TYPE;
            ST_ERR:    if (go) state_d = ST_TYPE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // The timer is reloaded on every phase change, with the new phase's length minus one.
    assign tmr_load = (state_d != state_q);

    always_comb begin
        case (state_d)
            ST_SETTLE: tmr_val = TW'(SETTLE_CYC - 1);
            ST_PERST:  tmr_val = TW'(PERST_CYC - 1);
            ST_LINK:   tmr_val = TW'(TMO_CYC - 1);
            ST_QUIET:  tmr_val = TW'(QUIET_CYC - 1);
            default:   tmr_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // R9: go cannot pull a sequence in progress back to the start.
    a_r9_go_ignored_busy: assert property (@(posedge clk) disable iff (rst)
        (state_q inside {ST_TYPE, ST_PWR, ST_SETTLE, ST_PHY, ST_REGS, ST_PERST, ST_LINK, ST_QUIET})
        |=> (state_q != ST_TYPE));

endmodule

// File: rtl/rp_ctl_regs.sv
module rp_ctl_regs
    import rp_bringup_pkg::*;
#(
    parameter bit HAS_PERST = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  seq_state_e state_d,
    output ctl_t       ctl_q
);
    ctl_t raw;
    ctl_t ctl_d;

    assign raw = ctl_for(state_d);

    generate
        if (HAS_PERST) begin : g_pin
            assign ctl_d = raw;
        end else begin : g_nopin
            always_comb begin
                ctl_d         = raw;
                ctl_d.perst_n = 1'b1;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= CTL_IDLE;
        else     ctl_q <= ctl_d;
    end

endmodule

// File: rtl/rp_bringup_seq.sv
module rp_bringup_seq
    import rp_bringup_pkg::*;
#(
    parameter int unsigned CLK_MHZ     = 250,
    parameter bit          HAS_PERST   = 1'b1,
    parameter int unsigned SETTLE_US   = 1000,
    parameter int unsigned PERST_US    = 100,
    parameter int unsigned QUIET_US    = 100000,
    parameter int unsigned LINK_TMO_US = 200000
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  logic phy_done,
    input  logic link_up,
    output logic rc_mode,
    output logic pwr_down,
    output logic soft_rst,
    output logic phy_init_req,
    output logic regs_setup,
    output logic perst_n,
    output logic ltssm_en,
    output logic cfg_ready,
    output logic link_err
);
    localparam int unsigned SETTLE_CYC = us_to_cyc(CLK_MHZ, SETTLE_US);
    localparam int unsigned PERST_CYC  = us_to_cyc(CLK_MHZ, PERST_US);
    localparam int unsigned QUIET_CYC  = us_to_cyc(CLK_MHZ, QUIET_US);
    localparam int unsigned TMO_CYC    = us_to_cyc(CLK_MHZ, LINK_TMO_US);
    localparam int unsigned MAX_CYC    = max_of(max_of(SETTLE_CYC, PERST_CYC),
                                                max_of(QUIET_CYC, TMO_CYC));
    localparam int          TW         = $clog2(MAX_CYC + 1);

    seq_state_e    state_d;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_expired;
    ctl_t          ctl;

    rp_seq_ctrl #(
        .HAS_PERST (HAS_PERST),
        .TW        (TW),
        .SETTLE_CYC(SETTLE_CYC),
        .PERST_CYC (PERST_CYC),
        .QUIET_CYC (QUIET_CYC),
        .TMO_CYC   (TMO_CYC)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .go         (go),
        .phy_done   (phy_done),
        .link_up    (link_up),
        .tmr_expired(tmr_expired),
        .state_d    (state_d),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val)
    );

    rp_phase_timer #(.TW(TW)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .load_val(tmr_val),
        .expired (tmr_expired)
    );

    rp_ctl_regs #(.HAS_PERST(HAS_PERST)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .state_d(state_d),
        .ctl_q  (ctl)
    );

    assign rc_mode      = ctl.rc_mode;
    assign pwr_down     = ctl.pwr_down;
    assign soft_rst     = ctl.soft_rst;
    assign phy_init_req = ctl.phy_req;
    assign regs_setup   = ctl.regs_stb;
    assign perst_n      = ctl.perst_n;
    assign ltssm_en     = ctl.ltssm_en;
    assign cfg_ready    = ctl.cfg_ready;
    assign link_err     = ctl.link_err;

    // R2: powerdown is released only in root-complex mode, while soft reset is still asserted.
    a_r2_pwr_before_rst: assert property (@(posedge clk) disable iff (rst)
        $fell(pwr_down) |-> (rc_mode && soft_rst));

    // R2: soft reset is released only after powerdown has been released.
    a_r2_rst_after_pwr: assert property (@(posedge clk) disable iff (rst)
        $fell(soft_rst) |-> (!pwr_down && rc_mode));

    // R4: training stays off while the PHY is being initialised.
    a_r4_phy_no_train: assert property (@(posedge clk) disable iff (rst)
        phy_init_req |-> !ltssm_en);

    // R5: the register-setup strobe lasts a single cycle.
    a_r5_strobe_single: assert property (@(posedge clk) disable iff (rst)
        regs_setup |=> !regs_setup);

    // R6: no training while the fundamental reset is driven; training starts as the reset is released.
    a_r6_no_train_in_perst: assert property (@(posedge clk) disable iff (rst)
        !perst_n |-> !ltssm_en);
    a_r6_train_on_release: assert property (@(posedge clk) disable iff (rst)
        $rose(perst_n) |-> ltssm_en);

    // R7: ready implies both resets are released and training is enabled.
    a_r7_ready_trained: assert property (@(posedge clk) disable iff (rst)
        cfg_ready |-> (ltssm_en && !pwr_down && !soft_rst));

    // R8: the error state has training off and is never ready.
    a_r8_err_quiet: assert property (@(posedge clk) disable iff (rst)
        link_err |-> (!ltssm_en && !cfg_ready));

    // R8: the error state persists until go.
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
        (link_err && !go) |=> link_err);

endmodule

// File: tb/sim_rp_bringup_seq.sv
module sim_rp_bringup_seq;
    localparam time CYC = 4ns;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic go = 1'b0, phy_done = 1'b0, link_up = 1'b0;
    logic rc_mode, pwr_down, soft_rst, phy_init_req, regs_setup, perst_n, ltssm_en, cfg_ready, link_err;
    logic go1 = 1'b0, lu1 = 1'b0;
    logic rc1, pd1, sr1, phy1, stb1, pn1, lt1, rdy1, err1;

    int vectors = 0;
    int errors  = 0;
    bit finished = 1'b0;
    bit saw_perst1_low = 1'b0;

    always #(CYC/2) clk = ~clk;

    rp_bringup_seq #(.CLK_MHZ(1), .HAS_PERST(1'b1), .SETTLE_US(20), .PERST_US(10),
                     .QUIET_US(30), .LINK_TMO_US(40)) u0 (
        .clk(clk), .rst(rst), .go(go), .phy_done(phy_done), .link_up(link_up),
        .rc_mode(rc_mode), .pwr_down(pwr_down), .soft_rst(soft_rst), .phy_init_req(phy_init_req),
        .regs_setup(regs_setup), .perst_n(perst_n), .ltssm_en(ltssm_en),
        .cfg_ready(cfg_ready), .link_err(link_err));

    rp_bringup_seq #(.CLK_MHZ(1), .HAS_PERST(1'b0), .SETTLE_US(20), .PERST_US(10),
                     .QUIET_US(30), .LINK_TMO_US(40)) u1 (
        .clk(clk), .rst(rst), .go(go1), .phy_done(1'b1), .link_up(lu1),
        .rc_mode(rc1), .pwr_down(pd1), .soft_rst(sr1), .phy_init_req(phy1),
        .regs_setup(stb1), .perst_n(pn1), .ltssm_en(lt1),
        .cfg_ready(rdy1), .link_err(err1));

    always @(negedge clk) if (!rst && !pn1) saw_perst1_low = 1'b1;

    // Expected pin patterns: {rc_mode,pwr_down,soft_rst,phy_init_req,regs_setup,perst_n,ltssm_en,cfg_ready,link_err}
    localparam logic [8:0] P_IDLE  = 9'b011001000;
    localparam logic [8:0] P_TYPE  = 9'b111001000;
    localparam logic [8:0] P_PWR   = 9'b101001000;
    localparam logic [8:0] P_SETL  = 9'b100001000;
    localparam logic [8:0] P_PHY   = 9'b100101000;
    localparam logic [8:0] P_REGS  = 9'b100011000;
    localparam logic [8:0] P_PERST = 9'b100000000;
    localparam logic [8:0] P_LINK  = 9'b100001100;
    localparam logic [8:0] P_READY = 9'b100001110;
    localparam logic [8:0] P_ERR   = 9'b100001001;

    // Row: {go, phy_done, link_up, cycles, expected pattern}
    localparam int NV = 27;
    localparam logic [19:0] VEC [NV] = '{
        {3'b100, 8'd1,  P_IDLE},   // R1 go accepted in idle
        {3'b000, 8'd1,  P_TYPE},   // R2
        {3'b000, 8'd1,  P_PWR},    // R2
        {3'b000, 8'd10, P_SETL},   // R3
        {3'b100, 8'd1,  P_SETL},   // R9 go ignored while settling
        {3'b000, 8'd9,  P_SETL},   // R3 total 20 cycles
        {3'b000, 8'd5,  P_PHY},    // R4 request held
        {3'b010, 8'd1,  P_PHY},    // R4 done sampled
        {3'b000, 8'd1,  P_REGS},   // R5
        {3'b000, 8'd10, P_PERST},  // R6
        {3'b000, 8'd7,  P_LINK},   // R6 training with reset released
        {3'b001, 8'd1,  P_LINK},   // R7 link up sampled
        {3'b001, 8'd30, P_LINK},   // R7 quiet period
        {3'b001, 8'd3,  P_READY},  // R7
        {3'b101, 8'd1,  P_READY},  // R9 restart from ready
        {3'b000, 8'd1,  P_TYPE},   // R9 resets re-asserted
        {3'b000, 8'd1,  P_PWR},
        {3'b000, 8'd20, P_SETL},
        {3'b010, 8'd1,  P_PHY},    // R4 immediate done
        {3'b000, 8'd1,  P_REGS},
        {3'b000, 8'd10, P_PERST},
        {3'b000, 8'd40, P_LINK},   // R8 timeout window
        {3'b001, 8'd4,  P_ERR},    // R8 link_up ignored in error
        {3'b100, 8'd1,  P_ERR},    // R9 restart from error
        {3'b000, 8'd1,  P_TYPE},
        {3'b000, 8'd1,  P_PWR},
        {3'b000, 8'd20, P_SETL}
    };

    function automatic logic [8:0] pins0();
        return {rc_mode, pwr_down, soft_rst, phy_init_req, regs_setup, perst_n, ltssm_en, cfg_ready, link_err};
    endfunction

    task automatic check_bit(string req, logic act, logic exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    initial begin
        #(CYC * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        vectors++;
        if (pins0() !== P_IDLE) begin
            errors++;
            $display("FAIL R1 reset: actual %b expected %b", pins0(), P_IDLE);
        end

        for (int i = 0; i < NV; i++) begin
            bit bad = 1'b0;
            logic [8:0] got = '0;
            vectors++;
            for (int c = 0; c < int'(VEC[i][16:9]); c++) begin
                go       = VEC[i][19];
                phy_done = VEC[i][18];
                link_up  = VEC[i][17];
                if (!bad && pins0() !== VEC[i][8:0]) begin
                    bad = 1'b1;
                    got = pins0();
                    $display("FAIL R1-R9 table row %0d cycle %0d: actual %b expected %b", i, c, got, VEC[i][8:0]);
                end
                @(posedge clk);
                @(negedge clk);
            end
            if (bad) errors++;
        end
        go = 1'b0; phy_done = 1'b0; link_up = 1'b0;

        // R1: reset mid-sequence returns to idle
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        vectors++;
        if (pins0() !== P_IDLE) begin
            errors++;
            $display("FAIL R1 reset mid-run: actual %b expected %b", pins0(), P_IDLE);
        end

        // R10: instance without a fundamental-reset pin
        go1 = 1'b1;
        @(posedge clk);
        @(negedge clk);
        go1 = 1'b0;
        repeat (23) begin
            @(posedge clk);
            @(negedge clk);
        end
        check_bit("R10 training off before strobe edge", lt1, 1'b0);
        @(posedge clk);
        @(negedge clk);
        check_bit("R10 training on edge after strobe", lt1, 1'b1);
        lu1 = 1'b1;
        check_bit("R10 not ready before link_up edge", rdy1, 1'b0);
        @(posedge clk);
        @(negedge clk);
        check_bit("R10 ready on link_up edge", rdy1, 1'b1);
        check_bit("R10 perst_n never low", saw_perst1_low, 1'b0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule